// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block sits between decode, the execution units and the architectural register file of a pipelined core. Decode claims a slot for each instruction in program order and receives the slot's tag. Execution units may finish in any order and deposit a result (and a fault flag) into the slot named by that tag. The buffer hands results to the register file only from the oldest slot, and only once that slot holds a result. In-flight instructions can overtake each other in execution, but the register file is still updated in program order.

When the oldest slot carries a fault flag, the result is not handed on. The buffer raises a one-cycle flush with the handler address, drops every slot, and restarts empty with both pointers at zero. A fault therefore becomes visible only when every older instruction has already committed and no younger one has. Depth, register-ID width, value width, address width and the handler address are parameters.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, `ret_valid`=0, `flush`=0.
- R2: Each accepted allocation (`alloc_req` with `alloc_ready`) takes the slot numbered `alloc_tag`. The next tag offered is one higher, modulo DEPTH.
- R3: Once DEPTH slots are held, `alloc_ready` is 0 and a request neither takes a slot nor moves `alloc_tag`.
- R4: A completion (`cmp_valid`) stores `cmp_value` and `cmp_exc` into the live slot named by `cmp_tag` and marks it done. Completions may arrive in any order.
- R5: Only the oldest slot may leave, and only once it is done. A done younger slot waits behind an unfinished older one, and an empty buffer presents nothing.
- R6: When the oldest slot is done without a fault, `ret_valid`=1 with its `ret_dest` and `ret_value` for exactly one cycle. The slot is then freed, so at most one slot leaves per cycle, in allocation order.
- R7: A completion naming a slot that is not currently held is ignored. A later occupant of that slot is not marked done by it.
- R8: When the oldest slot is done with its fault flag set, `flush`=1 and `redirect_addr`=HANDLER_ADDR for that cycle, and `ret_valid` stays 0.
- R9: The cycle after a flush, every slot is discarded: the buffer is empty, `alloc_tag`=0, `ret_valid`=0 and `flush`=0.
- R10: During a flush cycle `alloc_ready` is 0 and any allocation request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_dest | input | REG_W | Destination register ID of the new instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | log2(DEPTH) | Tag of the slot taken this cycle |
| cmp_valid | input | 1 | An execution unit delivers a result |
| cmp_tag | input | log2(DEPTH) | Slot the result belongs to |
| cmp_value | input | DATA_W | Result value |
| cmp_exc | input | 1 | Instruction raised a fault |
| ret_valid | output | 1 | Oldest slot commits this cycle |
| ret_dest | output | REG_W | Register ID to write |
| ret_value | output | DATA_W | Value to write |
| flush | output | 1 | Fault at the oldest slot; all slots discarded |
| redirect_addr | output | ADDR_W | Handler address while `flush` is 1, else 0 |

## Verification
A head pointer that slips shows up at the very next commit as a wrong `ret_dest`/`ret_value` pair, or as a commit while the oldest result is still missing. A tail pointer error appears on `alloc_tag` one cycle after the allocation that caused it. A lost or stale done bit shows within a cycle of the completion: either a commit happens too early, or the buffer stalls with `ret_valid` held low. A flush that leaves state behind shows one cycle later as a non-zero `alloc_tag` or a spurious commit.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      HEAD_IDLE   = 2'd0,
      HEAD_WAIT   = 2'd1,
      HEAD_COMMIT = 2'd2,
      HEAD_FAULT  = 2'd3
   } head_state_e;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             clr,
   output logic [IDX_W:0]   ptr
);
   // extra top bit tells a full ring from an empty one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (clr) ptr <= '0;
      else if (adv) ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/rob_store.sv
module rob_store #(
   parameter int DEPTH  = 8,
   parameter int REG_W  = 5,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic [REG_W-1:0]  alloc_dest,
   input  logic              cmp_en,
   input  logic [IDX_W-1:0]  cmp_idx,
   input  logic [DATA_W-1:0] cmp_value,
   input  logic              cmp_exc,
   input  logic              free_en,
   input  logic [IDX_W-1:0]  free_idx,
   input  logic              clear_all,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_done,
   output logic              rd_exc,
   output logic [REG_W-1:0]  rd_dest,
   output logic [DATA_W-1:0] rd_value
);
   logic [DEPTH-1:0]  valid_vec;
   logic [DEPTH-1:0]  done_vec;
   logic [DEPTH-1:0]  exc_vec;
   logic [REG_W-1:0]  dest_arr  [DEPTH];
   logic [DATA_W-1:0] value_arr [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic              v_q, d_q, e_q;
      logic [REG_W-1:0]  dest_q;
      logic [DATA_W-1:0] val_q;
      logic              hit_alloc, hit_free, hit_cmp;

      assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(i));
      assign hit_free  = free_en  && (free_idx  == IDX_W'(i));
      assign hit_cmp   = cmp_en   && (cmp_idx   == IDX_W'(i)) && v_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            e_q <= 1'b0;
         end else if (clear_all) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            e_q <= 1'b0;
         end else if (hit_alloc) begin
            v_q <= 1'b1;
            d_q <= 1'b0;
            e_q <= 1'b0;
         end else if (hit_free) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            e_q <= 1'b0;
         end else if (hit_cmp) begin
            d_q <= 1'b1;
            e_q <= cmp_exc;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_alloc) dest_q <= alloc_dest;
         if (hit_cmp && !hit_alloc && !clear_all) val_q <= cmp_value;
      end

      assign valid_vec[i] = v_q;
      assign done_vec[i]  = d_q;
      assign exc_vec[i]   = e_q;
      assign dest_arr[i]  = dest_q;
      assign value_arr[i] = val_q;
   end

   assign rd_valid = valid_vec[rd_idx];
   assign rd_done  = done_vec[rd_idx];
   assign rd_exc   = exc_vec[rd_idx];
   assign rd_dest  = dest_arr[rd_idx];
   assign rd_value = value_arr[rd_idx];
endmodule

// File: rtl/rob_head_ctl.sv
module rob_head_ctl
   import rob_pkg::*;
(
   input  logic        head_valid,
   input  logic        head_done,
   input  logic        head_exc,
   output head_state_e state,
   output logic        commit,
   output logic        fault
);
   always_comb begin
      if (!head_valid)     state = HEAD_IDLE;
      else if (!head_done) state = HEAD_WAIT;
      else if (head_exc)   state = HEAD_FAULT;
      else                 state = HEAD_COMMIT;
   end

   assign commit = (state == HEAD_COMMIT);
   assign fault  = (state == HEAD_FAULT);
endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int              DEPTH        = 8,
   parameter int              REG_W        = 5,
   parameter int              DATA_W       = 32,
   parameter int              ADDR_W       = 32,
   parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h100,
   localparam int             IDX_W        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic [REG_W-1:0]  alloc_dest,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_tag,
   input  logic              cmp_valid,
   input  logic [IDX_W-1:0]  cmp_tag,
   input  logic [DATA_W-1:0] cmp_value,
   input  logic              cmp_exc,
   output logic              ret_valid,
   output logic [REG_W-1:0]  ret_dest,
   output logic [DATA_W-1:0] ret_value,
   output logic              flush,
   output logic [ADDR_W-1:0] redirect_addr
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rob_core: DEPTH must be a power of two, at least 2");
   end
   if (REG_W < 1 || DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("rob_core: widths must be positive");
   end

   logic [IDX_W:0]    head_ptr, tail_ptr;
   logic              full, alloc_fire;
   logic              h_valid, h_done, h_exc;
   logic              do_commit, do_fault;
   head_state_e       h_state;

   assign full = (head_ptr[IDX_W] != tail_ptr[IDX_W]) &&
                 (head_ptr[IDX_W-1:0] == tail_ptr[IDX_W-1:0]);

   assign alloc_ready = !full && !do_fault;
   assign alloc_fire  = alloc_req && alloc_ready;
   assign alloc_tag   = tail_ptr[IDX_W-1:0];

   rob_ptr #(.IDX_W(IDX_W)) u_tail (
      .clk (clk), .rst_n (rst_n), .adv (alloc_fire), .clr (do_fault), .ptr (tail_ptr)
   );

   rob_ptr #(.IDX_W(IDX_W)) u_head (
      .clk (clk), .rst_n (rst_n), .adv (do_commit), .clr (do_fault), .ptr (head_ptr)
   );

   rob_store #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_fire),
      .alloc_idx  (tail_ptr[IDX_W-1:0]),
      .alloc_dest (alloc_dest),
      .cmp_en     (cmp_valid),
      .cmp_idx    (cmp_tag),
      .cmp_value  (cmp_value),
      .cmp_exc    (cmp_exc),
      .free_en    (do_commit),
      .free_idx   (head_ptr[IDX_W-1:0]),
      .clear_all  (do_fault),
      .rd_idx     (head_ptr[IDX_W-1:0]),
      .rd_valid   (h_valid),
      .rd_done    (h_done),
      .rd_exc     (h_exc),
      .rd_dest    (ret_dest),
      .rd_value   (ret_value)
   );

   rob_head_ctl u_ctl (
      .head_valid (h_valid),
      .head_done  (h_done),
      .head_exc   (h_exc),
      .state      (h_state),
      .commit     (do_commit),
      .fault      (do_fault)
   );

   assign ret_valid     = do_commit;
   assign flush         = do_fault;
   assign redirect_addr = do_fault ? HANDLER_ADDR : '0;
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_req,
   input logic             alloc_ready,
   input logic [IDX_W-1:0] alloc_tag,
   input logic             ret_valid,
   input logic             flush
);
   logic [IDX_W:0] occ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     occ <= '0;
      else if (flush) occ <= '0;
      else            occ <= occ + (IDX_W+1)'(alloc_req && alloc_ready) - (IDX_W+1)'(ret_valid);
   end

   // R3
   full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == (IDX_W+1)'(DEPTH)) |-> !alloc_ready);

   // R2
   tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && alloc_ready) |=> (alloc_tag == IDX_W'($past(alloc_tag) + 1'b1)));

   // R5
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> (!ret_valid && !flush));

   // R8
   commit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ret_valid && flush));

   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (alloc_tag == '0 && !ret_valid && !flush));

   // R10
   flush_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !alloc_ready);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_req   (alloc_req),
   .alloc_ready (alloc_ready),
   .alloc_tag   (alloc_tag),
   .ret_valid   (ret_valid),
   .flush       (flush)
);

// File: tb/rob_core_test.sv
module rob_core_test;
   localparam int DEPTH = 8;
   localparam int IDX_W = 3;
   localparam logic [31:0] HADDR = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_req = 1'b0;
   logic [4:0]  alloc_dest = '0;
   logic        alloc_ready;
   logic [2:0]  alloc_tag;
   logic        cmp_valid = 1'b0;
   logic [2:0]  cmp_tag = '0;
   logic [31:0] cmp_value = '0;
   logic        cmp_exc = 1'b0;
   logic        ret_valid;
   logic [4:0]  ret_dest;
   logic [31:0] ret_value;
   logic        flush;
   logic [31:0] redirect_addr;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rob_core #(.DEPTH(DEPTH), .REG_W(5), .DATA_W(32), .ADDR_W(32), .HANDLER_ADDR(HADDR)) uut (
      .clk (clk), .rst_n (rst_n),
      .alloc_req (alloc_req), .alloc_dest (alloc_dest),
      .alloc_ready (alloc_ready), .alloc_tag (alloc_tag),
      .cmp_valid (cmp_valid), .cmp_tag (cmp_tag), .cmp_value (cmp_value), .cmp_exc (cmp_exc),
      .ret_valid (ret_valid), .ret_dest (ret_dest), .ret_value (ret_value),
      .flush (flush), .redirect_addr (redirect_addr)
   );

   typedef struct packed {
      logic        al;
      logic [4:0]  ad;
      logic        cv;
      logic [2:0]  ct;
      logic [31:0] cd;
      logic        ce;
      logic [2:0]  etag;
      logic        erv;
      logic [4:0]  erd;
      logic [31:0] eval;
   } vec_t;

   // outputs checked reflect state before this row's clock edge
   localparam vec_t VEC [9] = '{
      '{1'b1, 5'd3, 1'b0, 3'd0, 32'h0,  1'b0, 3'd0, 1'b0, 5'd0, 32'h0},
      '{1'b1, 5'd4, 1'b0, 3'd0, 32'h0,  1'b0, 3'd1, 1'b0, 5'd0, 32'h0},
      '{1'b1, 5'd5, 1'b1, 3'd1, 32'h11, 1'b0, 3'd2, 1'b0, 5'd0, 32'h0},
      '{1'b0, 5'd0, 1'b1, 3'd2, 32'h22, 1'b0, 3'd3, 1'b0, 5'd0, 32'h0},
      '{1'b0, 5'd0, 1'b1, 3'd0, 32'h10, 1'b0, 3'd3, 1'b0, 5'd0, 32'h0},
      '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd3, 1'b1, 5'd3, 32'h10},
      '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd3, 1'b1, 5'd4, 32'h11},
      '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd3, 1'b1, 5'd5, 32'h22},
      '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd3, 1'b0, 5'd0, 32'h0}
   };

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic al, input logic [4:0] ad, input logic cv,
                       input logic [2:0] ct, input logic [31:0] cd, input logic ce);
      @(negedge clk);
      alloc_req = al; alloc_dest = ad;
      cmp_valid = cv; cmp_tag = ct; cmp_value = cd; cmp_exc = ce;
      #1;
   endtask

   task automatic idle();
      step(1'b0, 5'd0, 1'b0, 3'd0, 32'h0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
      chk(alloc_tag == 3'd0, "R1 tag", alloc_tag, 0);
      chk(ret_valid == 1'b0, "R1 ret_valid", ret_valid, 0);
      chk(flush == 1'b0, "R1 flush", flush, 0);

      // R4 R5 R6: out-of-order completion, in-order commit
      for (int i = 0; i < 9; i++) begin
         step(VEC[i].al, VEC[i].ad, VEC[i].cv, VEC[i].ct, VEC[i].cd, VEC[i].ce);
         chk(alloc_tag == VEC[i].etag, "R2 table tag", alloc_tag, VEC[i].etag);
         chk(ret_valid == VEC[i].erv, "R5 table ret_valid", ret_valid, VEC[i].erv);
         if (VEC[i].erv) begin
            chk(ret_dest == VEC[i].erd, "R6 table dest", ret_dest, VEC[i].erd);
            chk(ret_value == VEC[i].eval, "R4 table value", ret_value, VEC[i].eval);
         end
      end

      // R3: fill all slots starting at tag 3
      for (int k = 0; k < DEPTH; k++) begin
         step(1'b1, 5'(8 + k), 1'b0, 3'd0, 32'h0, 1'b0);
         chk(alloc_tag == 3'((3 + k) % DEPTH), "R2 fill tag", alloc_tag, (3 + k) % DEPTH);
      end
      step(1'b1, 5'd30, 1'b0, 3'd0, 32'h0, 1'b0);
      chk(alloc_ready == 1'b0, "R3 full ready", alloc_ready, 0);
      chk(alloc_tag == 3'd3, "R3 full tag", alloc_tag, 3);
      idle();
      chk(alloc_tag == 3'd3, "R3 refused request kept tag", alloc_tag, 3);
      chk(alloc_ready == 1'b0, "R3 still full", alloc_ready, 0);

      // R5: complete youngest first, nothing may leave until the oldest is done
      for (int k = DEPTH - 1; k >= 0; k--) begin
         step(1'b0, 5'd0, 1'b1, 3'((3 + k) % DEPTH), 32'(32'h100 + k), 1'b0);
         chk(ret_valid == 1'b0, "R5 wait behind oldest", ret_valid, 0);
      end
      // R6: one commit per cycle in allocation order
      for (int k = 0; k < DEPTH; k++) begin
         idle();
         chk(ret_valid == 1'b1, "R6 drain valid", ret_valid, 1);
         chk(ret_dest == 5'(8 + k), "R6 drain dest", ret_dest, 8 + k);
         chk(ret_value == 32'(32'h100 + k), "R6 drain value", ret_value, 32'h100 + k);
      end
      idle();
      chk(ret_valid == 1'b0, "R5 empty after drain", ret_valid, 0);
      chk(alloc_ready == 1'b1, "R3 ready after drain", alloc_ready, 1);

      // R7: completion to a freed slot is ignored
      step(1'b0, 5'd0, 1'b1, 3'd3, 32'h55, 1'b0);
      step(1'b1, 5'd1, 1'b0, 3'd0, 32'h0, 1'b0);
      chk(alloc_tag == 3'd3, "R7 tag of new occupant", alloc_tag, 3);
      idle();
      chk(ret_valid == 1'b0, "R7 stale completion ignored", ret_valid, 0);
      idle();
      chk(ret_valid == 1'b0, "R7 still waiting", ret_valid, 0);
      step(1'b0, 5'd0, 1'b1, 3'd3, 32'h77, 1'b0);
      idle();
      chk(ret_valid == 1'b1, "R7 commit after real result", ret_valid, 1);
      chk(ret_value == 32'h77, "R7 value", ret_value, 32'h77);
      chk(ret_dest == 5'd1, "R7 dest", ret_dest, 1);

      // R8 R9 R10: fault at the oldest slot
      step(1'b1, 5'd2, 1'b0, 3'd0, 32'h0, 1'b0);
      chk(alloc_tag == 3'd4, "R2 tag before fault", alloc_tag, 4);
      step(1'b1, 5'd6, 1'b0, 3'd0, 32'h0, 1'b0);
      step(1'b0, 5'd0, 1'b1, 3'd5, 32'h5, 1'b0);
      step(1'b0, 5'd0, 1'b1, 3'd4, 32'h9, 1'b1);
      chk(flush == 1'b0, "R8 no flush before fault completes", flush, 0);
      step(1'b1, 5'd7, 1'b0, 3'd0, 32'h0, 1'b0);
      chk(flush == 1'b1, "R8 flush", flush, 1);
      chk(redirect_addr == HADDR, "R8 redirect", redirect_addr, HADDR);
      chk(ret_valid == 1'b0, "R8 no commit of faulting slot", ret_valid, 0);
      chk(alloc_ready == 1'b0, "R10 alloc blocked in flush", alloc_ready, 0);
      idle();
      chk(flush == 1'b0, "R9 flush one cycle", flush, 0);
      chk(alloc_tag == 3'd0, "R9 tag reset", alloc_tag, 0);
      chk(ret_valid == 1'b0, "R9 younger slot discarded", ret_valid, 0);
      chk(alloc_ready == 1'b1, "R9 ready after flush", alloc_ready, 1);
      chk(redirect_addr == 32'h0, "R8 redirect idle", redirect_addr, 0);
      step(1'b1, 5'd9, 1'b0, 3'd0, 32'h0, 1'b0);
      step(1'b0, 5'd0, 1'b1, 3'd0, 32'hAA, 1'b0);
      chk(alloc_tag == 3'd1, "R10 request in flush dropped", alloc_tag, 1);
      idle();
      chk(ret_valid == 1'b1, "R9 restart commit", ret_valid, 1);
      chk(ret_dest == 5'd9, "R9 restart dest", ret_dest, 9);
      chk(ret_value == 32'hAA, "R9 restart value", ret_value, 32'hAA);
      idle();
      chk(ret_valid == 1'b0, "R9 no stale slot", ret_valid, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule